// File: doc/BRIEF.md
# Line-Gated Parallel Pixel Capture with Three Line Buffers

This block takes bytes from a camera-style parallel bus and stores them in a small ring of line buffers. It runs only as a slave on the sensor's pixel clock. A line-valid input frames each burst of samples. Samples are stored only while line-valid is high, and each buffer is closed when it fills or when the line ends. A consumer then reads every closed buffer byte by byte, together with the number of bytes it holds.

The sensor bus can be 5 or 8 bits wide. An optional decimation keeps only the odd-numbered samples of each line. In frame mode, a frame-sync pulse arms the unit, and it takes exactly as many lines as the selected resolution has: a short frame or a tall frame. In normal mode frame-sync has no effect. A line longer than the free storage loses its tail. A line that starts when no buffer is free is lost entirely.

Top module: `line_capture_tribuf`

## Requirements
- R1: After reset no buffer is offered: `rd_avail` is 0.
- R2: Nothing is stored while `cap_en` is 0, and nothing is stored from samples taken while `hsync` is 0.
- R3: With `wide_sel`=1 a stored byte equals `din`. With `wide_sel`=0 it is {3'b000, din[4:0]}.
- R4: With `odd_only`=1 only samples 1, 3, 5, … are stored. Numbering restarts at 1 on the first high-`hsync` sample of every line.
- R5: When `hsync` falls, a partly filled buffer is closed and offered with its byte count. An open buffer that holds no byte is returned to the free pool and is never offered.
- R6: A buffer that reaches BUF_BYTES bytes is closed with count BUF_BYTES. The same line continues into the next free buffer without waiting for a new `hsync` rise.
- R7: When no buffer is free, the remaining samples of the line are dropped. A line that begins with no free buffer is dropped whole. Buffers already closed stay intact.
- R8: Buffers are offered in the order they were filled. Data of a new line always starts a new buffer, and only on an `hsync` rise.
- R9: With `frame_mode`=1, lines are taken only after a `vsync` rise. Exactly FRAME_LINES_LO lines (`res_sel`=0) or FRAME_LINES_HI lines (`res_sel`=1) are taken, and further lines are ignored until the next `vsync` rise. With `frame_mode`=0, `vsync` has no effect.
- R10: While `rd_avail`=1:
  - `rd_len` gives the count of the oldest closed buffer.
  - `rd_data` gives its current byte, starting at byte 0.
  - `rd_pop` advances to the next byte.
  - `rd_last` is 1 exactly on the final byte.
  - Popping the final byte frees the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Pixel clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Parallel capture selected |
| wide_sel | input | 1 | 1: 8-bit samples, 0: 5-bit samples |
| odd_only | input | 1 | 1: keep odd-numbered samples only |
| frame_mode | input | 1 | 1: frame mode armed by vsync, 0: normal mode |
| res_sel | input | 1 | Frame height select (0: short, 1: tall) |
| vsync | input | 1 | Frame sync |
| hsync | input | 1 | Line valid |
| din | input | 8 | Sensor data bus |
| rd_pop | input | 1 | Consumer takes the current byte |
| rd_avail | output | 1 | A closed buffer is ready |
| rd_data | output | 8 | Current byte of the oldest closed buffer |
| rd_len | output | $clog2(BUF_BYTES+1) | Byte count of that buffer |
| rd_last | output | 1 | Current byte is the buffer's last |

## Verification
The bench builds the block with BUF_BYTES=8 and with frame heights of 3 and 4 lines. Short lines can then fill the buffers, spill across buffers, land exactly on a buffer boundary and exhaust all three buffers, each within a few dozen cycles. The small heights let full frames of both sizes, the line after the last accepted one and re-arming by `vsync` all be checked in one short run.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {
    BUF_FREE = 2'd0,
    BUF_FILL = 2'd1,
    BUF_DONE = 2'd2
  } buf_st_e;

  // Byte stored for one sensor sample; narrow bus keeps the low five bits.
  function automatic logic [7:0] fmt_sample(input logic [7:0] d, input logic wide);
    return wide ? d : {3'b000, d[4:0]};
  endfunction

  // Sample keep decision under odd-sample decimation.
  function automatic logic keep_sample(input logic odd_sel, input logic is_odd);
    return !odd_sel || is_odd;
  endfunction

endpackage

// File: rtl/cap_line_ctl.sv
module cap_line_ctl
  import cap_pkg::*;
#(
  parameter int FRAME_LINES_LO = 240,
  parameter int FRAME_LINES_HI = 288
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_en,
  input  logic       wide_sel,
  input  logic       odd_only,
  input  logic       frame_mode,
  input  logic       res_sel,
  input  logic       vsync,
  input  logic       hsync,
  input  logic [7:0] din,
  output logic       line_start,
  output logic       line_end,
  output logic       wr_en,
  output logic [7:0] wr_byte
);

  localparam int LMAX = (FRAME_LINES_HI > FRAME_LINES_LO) ? FRAME_LINES_HI : FRAME_LINES_LO;
  localparam int LW   = $clog2(LMAX + 1);

  logic          hs_q, vs_q, par_q, armed_q;
  logic [LW-1:0] lines_q;
  logic          hs_rise, hs_fall, vs_rise, odd_now, accept;
  logic [LW-1:0] target;

  assign hs_rise    = hsync & ~hs_q;
  assign hs_fall    = ~hsync & hs_q;
  assign vs_rise    = vsync & ~vs_q;
  assign target     = res_sel ? LW'(FRAME_LINES_HI) : LW'(FRAME_LINES_LO);
  assign accept     = frame_mode ? armed_q : 1'b1;
  assign odd_now    = hs_rise | ~par_q;
  assign line_start = hs_rise & cap_en & accept;
  assign line_end   = hs_fall;
  assign wr_en      = hsync & cap_en & keep_sample(odd_only, odd_now);
  assign wr_byte    = fmt_sample(din, wide_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q    <= 1'b0;
      vs_q    <= 1'b0;
      par_q   <= 1'b0;
      armed_q <= 1'b0;
      lines_q <= '0;
    end else begin
      hs_q <= hsync;
      vs_q <= vsync;
      if (hsync) par_q <= odd_now;
      if (!frame_mode) begin
        armed_q <= 1'b0;
        lines_q <= '0;
      end else if (vs_rise) begin
        armed_q <= 1'b1;
        lines_q <= '0;
      end else if (hs_rise && armed_q) begin
        lines_q <= lines_q + LW'(1);
        if (lines_q + LW'(1) == target) armed_q <= 1'b0;
      end
    end
  end

  // R9
  frame_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_mode && !armed_q) |-> !line_start);

  // R4
  odd_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_only && $past(odd_only) && hsync && $past(hsync) && $past(wr_en)) |-> !wr_en);

endmodule

// File: rtl/cap_buf_bank.sv
module cap_buf_bank
  import cap_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  parameter int NUM_BUFS  = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           line_start,
  input  logic                           line_end,
  input  logic                           wr_en,
  input  logic [7:0]                     wr_byte,
  input  logic                           rd_pop,
  output logic                           rd_avail,
  output logic [7:0]                     rd_data,
  output logic [$clog2(BUF_BYTES+1)-1:0] rd_len,
  output logic                           rd_last,
  output logic                           wr_fire
);

  localparam int CW = $clog2(BUF_BYTES + 1);
  localparam int IW = $clog2(BUF_BYTES);
  localparam int PW = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1;

  function automatic logic [PW-1:0] ring_next(input logic [PW-1:0] p);
    return (p == PW'(NUM_BUFS - 1)) ? '0 : p + PW'(1);
  endfunction

  buf_st_e       st_q  [NUM_BUFS];
  logic [CW-1:0] len_q [NUM_BUFS];
  logic [7:0]    mem_q [NUM_BUFS][BUF_BYTES];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q, nxt_wp;
  logic [CW-1:0] wcnt_q, wr_idx, wr_cnt_n;
  logic [IW-1:0] rd_idx_q;
  logic          open_q, can_open, start_ok, eff_open, buf_full, nxt_free, rd_done;
  logic [NUM_BUFS-1:0] fill_vec;

  assign can_open = (st_q[wr_ptr_q] == BUF_FREE);
  assign start_ok = line_start & can_open;
  assign eff_open = open_q | start_ok;
  assign wr_fire  = eff_open & wr_en;
  assign wr_idx   = start_ok ? '0 : wcnt_q;
  assign wr_cnt_n = wr_idx + CW'(1);
  assign buf_full = wr_fire && (wr_cnt_n == CW'(BUF_BYTES));
  assign nxt_wp   = ring_next(wr_ptr_q);
  assign nxt_free = (st_q[nxt_wp] == BUF_FREE);

  assign rd_avail = (st_q[rd_ptr_q] == BUF_DONE);
  assign rd_len   = len_q[rd_ptr_q];
  assign rd_data  = mem_q[rd_ptr_q][rd_idx_q];
  assign rd_last  = rd_avail && ((CW'(rd_idx_q) + CW'(1)) == rd_len);
  assign rd_done  = rd_pop & rd_last;

  for (genvar g = 0; g < NUM_BUFS; g++) begin : g_fill
    assign fill_vec[g] = (st_q[g] == BUF_FILL);
  end

  always_ff @(posedge clk) begin
    if (wr_fire) mem_q[wr_ptr_q][wr_idx[IW-1:0]] <= wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BUFS; b++) begin
        st_q[b]  <= BUF_FREE;
        len_q[b] <= '0;
      end
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      rd_idx_q <= '0;
      wcnt_q   <= '0;
      open_q   <= 1'b0;
    end else begin
      // consumer side: only ever touches a closed buffer
      if (rd_done) begin
        st_q[rd_ptr_q] <= BUF_FREE;
        rd_ptr_q       <= ring_next(rd_ptr_q);
        rd_idx_q       <= '0;
      end else if (rd_pop && rd_avail) begin
        rd_idx_q <= rd_idx_q + IW'(1);
      end
      // capture side: only ever touches free or filling buffers
      if (line_end && open_q) begin
        if (wcnt_q != '0) begin
          st_q[wr_ptr_q]  <= BUF_DONE;
          len_q[wr_ptr_q] <= wcnt_q;
          wr_ptr_q        <= nxt_wp;
        end else begin
          st_q[wr_ptr_q] <= BUF_FREE;
        end
        wcnt_q <= '0;
        open_q <= 1'b0;
      end else if (buf_full) begin
        st_q[wr_ptr_q]  <= BUF_DONE;
        len_q[wr_ptr_q] <= CW'(BUF_BYTES);
        wr_ptr_q        <= nxt_wp;
        wcnt_q          <= '0;
        if (nxt_free) begin
          st_q[nxt_wp] <= BUF_FILL;
          open_q       <= 1'b1;
        end else begin
          open_q <= 1'b0;
        end
      end else if (wr_fire) begin
        st_q[wr_ptr_q] <= BUF_FILL;
        wcnt_q         <= wr_cnt_n;
        open_q         <= 1'b1;
      end else if (start_ok) begin
        st_q[wr_ptr_q] <= BUF_FILL;
        wcnt_q         <= '0;
        open_q         <= 1'b1;
      end
    end
  end

  // R6
  one_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_vec));

  // R10
  rd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_avail |-> (rd_len != '0) && (CW'(rd_idx_q) < rd_len));

  // R8
  rd_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && rd_last) |=> (rd_ptr_q == ring_next($past(rd_ptr_q))));

endmodule

// File: rtl/line_capture_tribuf.sv
module line_capture_tribuf
  import cap_pkg::*;
#(
  parameter int BUF_BYTES      = 64,
  parameter int NUM_BUFS       = 3,
  parameter int FRAME_LINES_LO = 240,
  parameter int FRAME_LINES_HI = 288
) (
  input  logic                           pclk,
  input  logic                           rst_n,
  input  logic                           cap_en,
  input  logic                           wide_sel,
  input  logic                           odd_only,
  input  logic                           frame_mode,
  input  logic                           res_sel,
  input  logic                           vsync,
  input  logic                           hsync,
  input  logic [7:0]                     din,
  input  logic                           rd_pop,
  output logic                           rd_avail,
  output logic [7:0]                     rd_data,
  output logic [$clog2(BUF_BYTES+1)-1:0] rd_len,
  output logic                           rd_last
);

  logic       line_start, line_end, wr_en, wr_fire;
  logic [7:0] wr_byte;

  cap_line_ctl #(
    .FRAME_LINES_LO(FRAME_LINES_LO),
    .FRAME_LINES_HI(FRAME_LINES_HI)
  ) u_ctl (
    .clk       (pclk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .wide_sel  (wide_sel),
    .odd_only  (odd_only),
    .frame_mode(frame_mode),
    .res_sel   (res_sel),
    .vsync     (vsync),
    .hsync     (hsync),
    .din       (din),
    .line_start(line_start),
    .line_end  (line_end),
    .wr_en     (wr_en),
    .wr_byte   (wr_byte)
  );

  cap_buf_bank #(
    .BUF_BYTES(BUF_BYTES),
    .NUM_BUFS (NUM_BUFS)
  ) u_bank (
    .clk       (pclk),
    .rst_n     (rst_n),
    .line_start(line_start),
    .line_end  (line_end),
    .wr_en     (wr_en),
    .wr_byte   (wr_byte),
    .rd_pop    (rd_pop),
    .rd_avail  (rd_avail),
    .rd_data   (rd_data),
    .rd_len    (rd_len),
    .rd_last   (rd_last),
    .wr_fire   (wr_fire)
  );

  // R2
  wr_gate_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    wr_fire |-> (hsync && cap_en));

  // R3
  narrow_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    (wr_fire && !wide_sel) |-> (wr_byte[7:5] == 3'b000));

endmodule

// File: tb/test_line_capture_tribuf.sv
module test_line_capture_tribuf;

  localparam int BB  = 8;
  localparam int NB  = 3;
  localparam int LLO = 3;
  localparam int LHI = 4;
  localparam int CW  = $clog2(BB + 1);

  logic          pclk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cap_en = 1'b1, wide_sel = 1'b1, odd_only = 1'b0;
  logic          frame_mode = 1'b0, res_sel = 1'b0, vsync = 1'b0, hsync = 1'b0;
  logic [7:0]    din = 8'h00;
  logic          rd_pop = 1'b0;
  logic          rd_avail, rd_last;
  logic [7:0]    rd_data;
  logic [CW-1:0] rd_len;

  int     checks = 0;
  int     errors = 0;
  bit     reader_on = 1'b1;
  int     mon_idx = 0;
  int     mon_len = 0;
  logic [7:0] exp_b[$];
  string      exp_t[$];
  int         exp_l[$];

  always #2 pclk = ~pclk;

  line_capture_tribuf #(
    .BUF_BYTES(BB), .NUM_BUFS(NB), .FRAME_LINES_LO(LLO), .FRAME_LINES_HI(LHI)
  ) i_line_capture_tribuf (
    .pclk(pclk), .rst_n(rst_n), .cap_en(cap_en), .wide_sel(wide_sel),
    .odd_only(odd_only), .frame_mode(frame_mode), .res_sel(res_sel),
    .vsync(vsync), .hsync(hsync), .din(din), .rd_pop(rd_pop),
    .rd_avail(rd_avail), .rd_data(rd_data), .rd_len(rd_len), .rd_last(rd_last)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] sample_val(input int seed, input int i);
    return 8'((seed + i * 37) & 255);
  endfunction

  // Scoreboard driver: predicts the buffers a line yields, then drives it.
  task automatic send_line(input int n, input int seed, input int free_b,
                           input bit taken, input string tag);
    int cur = 0;
    bit have = 1'b0;
    if (taken && free_b > 0) begin have = 1'b1; free_b--; end
    for (int i = 0; i < n; i++) begin
      logic [7:0] v = sample_val(seed, i);
      if (have && (!odd_only || (i % 2 == 0))) begin
        exp_b.push_back(wide_sel ? v : (v & 8'h1F));
        exp_t.push_back(tag);
        cur++;
        if (cur == BB) begin
          exp_l.push_back(BB);
          cur = 0;
          if (free_b > 0) free_b--; else have = 1'b0;
        end
      end
    end
    if (have && cur > 0) exp_l.push_back(cur);
    for (int i = 0; i < n; i++) begin
      @(negedge pclk);
      hsync = 1'b1;
      din   = sample_val(seed, i);
    end
    @(negedge pclk);
    hsync = 1'b0;
    for (int i = 0; i < 4; i++) begin
      din = 8'hA5 ^ 8'(i);            // R2: line-invalid samples must vanish
      @(negedge pclk);
    end
  endtask

  task automatic drain(input string tag);
    repeat (60) @(negedge pclk);
    check(exp_b.size() == 0, tag, "bytes still expected", exp_b.size(), 0);
    check(!rd_avail, tag, "buffer left over", rd_avail, 0);
  endtask

  task automatic vs_pulse();
    @(negedge pclk) vsync = 1'b1;
    @(negedge pclk) vsync = 1'b0;
  endtask

  // Scoreboard monitor: pops one byte per cycle when a buffer is offered.
  initial begin
    forever begin
      @(negedge pclk);
      rd_pop = 1'b0;
      if (rst_n && reader_on && rd_avail) begin
        if (exp_b.size() == 0) begin
          check(1'b0, "R7", "unexpected byte", rd_data, -1);
        end else begin
          logic [7:0] eb;
          string t;
          if (mon_idx == 0) begin
            mon_len = exp_l.pop_front();
            check(rd_len == CW'(mon_len), "R10", "buffer count", rd_len, mon_len);
          end
          eb = exp_b.pop_front();
          t  = exp_t.pop_front();
          check(rd_data == eb, t, "stored byte", rd_data, eb);
          check(rd_last == (mon_idx == mon_len - 1), "R10", "last flag",
                rd_last, (mon_idx == mon_len - 1));
          mon_idx = (mon_idx == mon_len - 1) ? 0 : mon_idx + 1;
        end
        rd_pop = 1'b1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge pclk);
    check(1'b0, "R10", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge pclk);
    check(!rd_avail, "R1", "offered after reset", rd_avail, 0);
    rst_n = 1'b1;
    @(negedge pclk);
    check(!rd_avail, "R1", "offered after reset release", rd_avail, 0);

    // R3 wide bus, R10 read-out
    send_line(5, 3, NB, 1'b1, "R3");
    drain("R10");
    // R3 narrow bus
    wide_sel = 1'b0;
    send_line(6, 200, NB, 1'b1, "R3");
    drain("R3");
    wide_sel = 1'b1;
    // R4 odd-only, parity restarts per line
    odd_only = 1'b1;
    send_line(7, 11, NB, 1'b1, "R4");
    send_line(6, 90, NB, 1'b1, "R4");
    drain("R4");
    odd_only = 1'b0;
    // R5 exact fill: spill buffer stays empty and is never offered
    send_line(BB, 40, NB, 1'b1, "R5");
    drain("R5");
    // R6 long line spills over buffers
    send_line(20, 60, NB, 1'b1, "R6");
    drain("R6");
    // R2 capture disabled
    cap_en = 1'b0;
    send_line(5, 77, NB, 1'b0, "R2");
    drain("R2");
    cap_en = 1'b1;
    // R7 overflow with consumer stalled
    reader_on = 1'b0;
    send_line(30, 5, NB, 1'b1, "R7");
    send_line(4, 150, 0, 1'b1, "R7");
    check(rd_avail, "R7", "stored buffers kept", rd_avail, 1);
    reader_on = 1'b1;
    drain("R7");
    // R8 partial lines stay separate and in order
    reader_on = 1'b0;
    send_line(3, 21, NB, 1'b1, "R8");
    send_line(5, 121, NB - 1, 1'b1, "R8");
    reader_on = 1'b1;
    drain("R8");
    // R9 frame mode, short height
    frame_mode = 1'b1;
    res_sel    = 1'b0;
    repeat (2) @(negedge pclk);
    send_line(2, 9, NB, 1'b0, "R9");
    vs_pulse();
    for (int l = 0; l < LLO; l++) send_line(2, 30 + l, NB, 1'b1, "R9");
    send_line(2, 99, NB, 1'b0, "R9");
    drain("R9");
    // R9 tall height
    res_sel = 1'b1;
    vs_pulse();
    for (int l = 0; l < LHI; l++) send_line(2, 130 + l, NB, 1'b1, "R9");
    send_line(2, 199, NB, 1'b0, "R9");
    drain("R9");
    // R9 normal mode ignores vsync
    frame_mode = 1'b0;
    vs_pulse();
    send_line(3, 55, NB, 1'b1, "R9");
    vs_pulse();
    send_line(3, 66, NB, 1'b1, "R9");
    drain("R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule